// File: doc/BRIEF.md
# Ring Node Packet Router

This block is the communication unit of a single processing node sitting in a ring of identical nodes. Packets arrive as a stream of 16-bit words on the incoming ring link. The router reads each packet's addressing class and identifier and then steers the packet in one of four ways. It can hand the packet to the local processor through a receive FIFO. It can pass the packet to the next node through a forwarding FIFO. It can do both, or it can absorb the packet completely. Node and group identities and the usable depth of both FIFOs are configuration inputs, which are loaded before traffic starts.

A packet is a three-word header followed by its payload. The first header word holds the class and an identifier, the second holds the payload length, and the third holds the identifier of the node that sent the packet. The outgoing ring link is shared by two sources: words leaving the forwarding FIFO, and packets the local processor injects through its own link. Each outgoing packet is kept whole on the link, and the two sources take turns at packet boundaries.

Every link uses a valid/ready handshake. A full FIFO stalls the upstream sender, and no word is ever lost.

Top module: `ring_node_router`

## Requirements
- R1: A packet is header word H, length word L, origin word O, then L payload words (3+L words in total; L=0 is legal). Class sits in H[15:14] (00 single node, 01 group, 10 broadcast, 11 host) and the identifier in H[13:0]. The origin identifier sits in O[13:0].
- R2: A single-node packet whose identifier equals the node ID goes only to the receive FIFO. Any other single-node packet goes only to the forwarding FIFO.
- R3: If a group packet's origin equals the node ID, the packet is absorbed: it is neither delivered nor forwarded. Otherwise the packet is always forwarded, and it is also delivered when its identifier equals the group ID.
- R4: If a broadcast packet's origin equals the node ID, the packet is absorbed. Otherwise it is both delivered and forwarded.
- R5: A host packet is only forwarded, and it is never delivered, even when its identifier equals the node ID.
- R6: Each copy of a packet carries all 3+L words unchanged and in their original order.
- R7: A word crosses a link only in a cycle where valid and ready are both high. The incoming ring link stalls while any FIFO the current packet targets is full. No word is dropped or duplicated under backpressure on any link.
- R8: Each FIFO counts as full when its occupancy reaches its configured limit. A limit of 0, or a limit above the storage depth, means the full storage depth. While a packet is stalled on a full receive FIFO, the incoming link accepts the three header words and then only as many further words as the limit leaves room for.
- R9: On the outgoing ring link, the words of two packets are never mixed. Once a packet's first word has left, its source keeps the link until the packet's last word has left.
- R10: When both sources hold a packet at a packet boundary, the source that did not send the previous packet wins. After reset, the first such tie goes to forwarded traffic.
- R11: Straight after reset, the receive and outgoing links show no valid word and the incoming ring link is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_node_id | input | 14 | Identifier of this node |
| cfg_group_id | input | 14 | Identifier of the group this node belongs to |
| cfg_rx_limit | input | LIM_W (5) | Usable depth of the receive FIFO (0 = full storage) |
| cfg_fwd_limit | input | LIM_W (5) | Usable depth of the forwarding FIFO (0 = full storage) |
| ring_in_valid | input | 1 | Incoming ring word valid |
| ring_in_data | input | 16 | Incoming ring word |
| ring_in_ready | output | 1 | Router accepts the incoming ring word |
| ring_out_valid | output | 1 | Outgoing ring word valid |
| ring_out_data | output | 16 | Outgoing ring word |
| ring_out_ready | input | 1 | Next node accepts the outgoing word |
| inj_valid | input | 1 | Local processor injection word valid |
| inj_data | input | 16 | Local processor injection word |
| inj_ready | output | 1 | Router accepts the injection word |
| rx_valid | output | 1 | Delivered word valid |
| rx_data | output | 16 | Delivered word to the local processor |
| rx_ready | input | 1 | Local processor accepts the delivered word |

## Verification
Forwarded traffic leaving the forwarding FIFO and a packet injected by the local processor can both ask for the outgoing ring link in the same cycle. To provoke this, the bench holds the outgoing link stalled until two forwarded packets are queued and the injection link is already presenting a packet, and then releases the link. The result is judged in two ways. The order of packet starts on the link must alternate forwarded, injected, forwarded, injected. Each outgoing word must also match the next word of its own packet, so any mixing of packets shows up as a mismatch. A second overlap is checked as well: a broadcast writes the same word into both FIFOs in one cycle, and this is exercised while both the receive link and the outgoing link are throttled.

// File: rtl/rnr_pkg.sv
package rnr_pkg;
  localparam int WORD_W    = 16;
  localparam int ID_W      = 14;
  localparam int HDR_WORDS = 3;

  typedef enum logic [1:0] {
    CLS_NODE  = 2'b00,
    CLS_GROUP = 2'b01,
    CLS_BCAST = 2'b10,
    CLS_HOST  = 2'b11
  } addr_class_e;

  typedef enum logic [1:0] {
    ST_CAP    = 2'd0,
    ST_REPLAY = 2'd1,
    ST_BODY   = 2'd2
  } cls_state_e;
endpackage

// File: rtl/rnr_fifo.sv
module rnr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          not_empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d, eff_limit;

  always_comb begin
    eff_limit = ((limit == '0) || (limit > CW'(DEPTH))) ? CW'(DEPTH) : limit;
    full      = (cnt_q >= eff_limit);
    not_empty = (cnt_q != '0);
    rd_data   = mem[rptr_q];
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (rd_en) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
    else if (!wr_en && rd_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> cnt_q < CW'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> cnt_q != '0);        // R7
endmodule

// File: rtl/rnr_classifier.sv
module rnr_classifier
  import rnr_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int IW = ID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] node_id,
  input  logic [IW-1:0] group_id,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  input  logic          rx_full,
  input  logic          fwd_full,
  output logic          rx_wr,
  output logic          fwd_wr,
  output logic [W-1:0]  wr_data
);
  cls_state_e   st_q, st_d;
  logic [1:0]   cnt_q, cnt_d;
  logic [W-1:0] hdr_q [HDR_WORDS];
  logic [W-1:0] hdr_d [HDR_WORDS];
  logic [W-1:0] rem_q, rem_d;
  logic         dlv_q, dlv_d, fwd_q, fwd_d;
  logic         space, hs, emit;
  logic [1:0]   verdict;

  function automatic logic [1:0] decide(input logic [W-1:0] h0, input logic [IW-1:0] origin,
                                        input logic [IW-1:0] nid, input logic [IW-1:0] gid);
    logic [IW-1:0] id;
    id = h0[IW-1:0];
    case (addr_class_e'(h0[W-1:W-2]))
      CLS_NODE:  decide = {id == nid, id != nid};
      CLS_GROUP: decide = (origin == nid) ? 2'b00 : {id == gid, 1'b1};
      CLS_BCAST: decide = (origin == nid) ? 2'b00 : 2'b11;
      default:   decide = 2'b01;
    endcase
  endfunction

  always_comb begin
    space    = (!dlv_q || !rx_full) && (!fwd_q || !fwd_full);
    in_ready = (st_q == ST_CAP) || ((st_q == ST_BODY) && space);
    hs       = in_valid && in_ready;
    emit     = ((st_q == ST_REPLAY) && space) || ((st_q == ST_BODY) && hs);
    wr_data  = (st_q == ST_REPLAY) ? hdr_q[cnt_q] : in_data;
    rx_wr    = emit && dlv_q;
    fwd_wr   = emit && fwd_q;
    verdict  = decide(hdr_q[0], in_data[IW-1:0], node_id, group_id);

    st_d  = st_q;
    cnt_d = cnt_q;
    hdr_d = hdr_q;
    rem_d = rem_q;
    dlv_d = dlv_q;
    fwd_d = fwd_q;
    case (st_q)
      ST_CAP: if (hs) begin
        hdr_d[cnt_q] = in_data;
        if (cnt_q == 2'd2) begin
          st_d  = ST_REPLAY;
          cnt_d = '0;
          {dlv_d, fwd_d} = verdict;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REPLAY: if (space) begin
        if (cnt_q == 2'd2) begin
          cnt_d = '0;
          rem_d = hdr_q[1];
          st_d  = (hdr_q[1] == '0) ? ST_CAP : ST_BODY;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: if (hs) begin
        rem_d = rem_q - 1'b1;
        if (rem_q == W'(1)) st_d = ST_CAP;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CAP;
      cnt_q <= '0;
      rem_q <= '0;
      dlv_q <= 1'b0;
      fwd_q <= 1'b0;
      for (int i = 0; i < HDR_WORDS; i++) hdr_q[i] <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      dlv_q <= dlv_d;
      fwd_q <= fwd_d;
      for (int i = 0; i < HDR_WORDS; i++) hdr_q[i] <= hdr_d[i];
    end
  end

  AST_RX_ROOM:     assert property (@(posedge clk) disable iff (!rst_n) rx_wr |-> !rx_full);   // R7
  AST_FWD_ROOM:    assert property (@(posedge clk) disable iff (!rst_n) fwd_wr |-> !fwd_full); // R7
  AST_NODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CAP && addr_class_e'(hdr_q[0][W-1:W-2]) == CLS_NODE) |-> !(dlv_q && fwd_q));   // R2
  AST_HOST_NO_DLV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CAP && addr_class_e'(hdr_q[0][W-1:W-2]) == CLS_HOST) |-> !dlv_q);              // R5
endmodule

// File: rtl/rnr_out_arb.sv
module rnr_out_arb #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fwd_valid,
  input  logic [W-1:0] fwd_data,
  output logic         fwd_rd,
  input  logic         inj_valid,
  input  logic [W-1:0] inj_data,
  output logic         inj_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam logic SRC_FWD = 1'b0;
  localparam logic SRC_INJ = 1'b1;

  logic         busy_q, busy_d, sel_q, sel_d, last_q, last_d;
  logic [W:0]   idx_q, idx_d;
  logic [W-1:0] len_q, len_d;
  logic         pick, cur_sel, fire, end_pkt;

  always_comb begin
    if (fwd_valid && inj_valid) pick = (last_q == SRC_FWD) ? SRC_INJ : SRC_FWD;
    else                        pick = inj_valid ? SRC_INJ : SRC_FWD;
    cur_sel   = busy_q ? sel_q : pick;
    out_valid = (cur_sel == SRC_INJ) ? inj_valid : fwd_valid;
    out_data  = (cur_sel == SRC_INJ) ? inj_data : fwd_data;
    fire      = out_valid && out_ready;
    fwd_rd    = fire && (cur_sel == SRC_FWD);
    inj_ready = out_ready && (cur_sel == SRC_INJ);
    end_pkt   = fire && (idx_q >= (W+1)'(2)) && ((idx_q - (W+1)'(2)) == {1'b0, len_q});

    busy_d = busy_q;
    sel_d  = sel_q;
    last_d = last_q;
    idx_d  = idx_q;
    len_d  = len_q;
    if (fire) begin
      if (idx_q == (W+1)'(1)) len_d = out_data;
      if (end_pkt) begin
        busy_d = 1'b0;
        idx_d  = '0;
        last_d = cur_sel;
      end else begin
        busy_d = 1'b1;
        sel_d  = cur_sel;
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= SRC_FWD;
      last_q <= SRC_INJ;
      idx_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
      last_q <= last_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_rd, inj_valid && inj_ready}));                                         // R9
  AST_NO_SWITCH:  assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fwd_rd) |-> (sel_q == SRC_FWD));                                          // R9
endmodule

// File: rtl/ring_node_router.sv
module ring_node_router
  import rnr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LIM_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_node_id,
  input  logic [ID_W-1:0]   cfg_group_id,
  input  logic [LIM_W-1:0]  cfg_rx_limit,
  input  logic [LIM_W-1:0]  cfg_fwd_limit,
  input  logic              ring_in_valid,
  input  logic [WORD_W-1:0] ring_in_data,
  output logic              ring_in_ready,
  output logic              ring_out_valid,
  output logic [WORD_W-1:0] ring_out_data,
  input  logic              ring_out_ready,
  input  logic              inj_valid,
  input  logic [WORD_W-1:0] inj_data,
  output logic              inj_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_ready
);
  logic              rst_meta, rst_sync;
  logic              rx_full, fwd_full, rx_wr, fwd_wr, fwd_ne, fwd_rd;
  logic [WORD_W-1:0] wr_data, fwd_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rnr_classifier #(.W(WORD_W), .IW(ID_W)) u_cls (
    .clk(clk), .rst_n(rst_sync),
    .node_id(cfg_node_id), .group_id(cfg_group_id),
    .in_valid(ring_in_valid), .in_data(ring_in_data), .in_ready(ring_in_ready),
    .rx_full(rx_full), .fwd_full(fwd_full),
    .rx_wr(rx_wr), .fwd_wr(fwd_wr), .wr_data(wr_data)
  );

  rnr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_sync), .limit(cfg_rx_limit),
    .wr_en(rx_wr), .wr_data(wr_data),
    .rd_en(rx_valid && rx_ready), .rd_data(rx_data),
    .not_empty(rx_valid), .full(rx_full)
  );

  rnr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fwd_fifo (
    .clk(clk), .rst_n(rst_sync), .limit(cfg_fwd_limit),
    .wr_en(fwd_wr), .wr_data(wr_data),
    .rd_en(fwd_rd), .rd_data(fwd_head),
    .not_empty(fwd_ne), .full(fwd_full)
  );

  rnr_out_arb #(.W(WORD_W)) u_arb (
    .clk(clk), .rst_n(rst_sync),
    .fwd_valid(fwd_ne), .fwd_data(fwd_head), .fwd_rd(fwd_rd),
    .inj_valid(inj_valid), .inj_data(inj_data), .inj_ready(inj_ready),
    .out_valid(ring_out_valid), .out_data(ring_out_data), .out_ready(ring_out_ready)
  );

  AST_IN_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_sync)
    (rx_wr && fwd_wr) |-> !(rx_full || fwd_full));                                      // R7
endmodule

// File: tb/ring_node_router_tb.sv
`timescale 1ns/1ps
module ring_node_router_tb;
  localparam logic [13:0] NID = 14'h0123;
  localparam logic [13:0] GID = 14'h0045;

  logic        clk, rst_n;
  logic [4:0]  cfg_rx_limit, cfg_fwd_limit;
  logic        ring_in_valid, ring_in_ready, ring_out_valid, ring_out_ready;
  logic [15:0] ring_in_data, ring_out_data, inj_data, rx_data;
  logic        inj_valid, inj_ready, rx_valid, rx_ready;

  ring_node_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_node_id(NID), .cfg_group_id(GID),
    .cfg_rx_limit(cfg_rx_limit), .cfg_fwd_limit(cfg_fwd_limit),
    .ring_in_valid(ring_in_valid), .ring_in_data(ring_in_data), .ring_in_ready(ring_in_ready),
    .ring_out_valid(ring_out_valid), .ring_out_data(ring_out_data), .ring_out_ready(ring_out_ready),
    .inj_valid(inj_valid), .inj_data(inj_data), .inj_ready(inj_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0, acc_cnt = 0;
  int rx_mode = 0, out_mode = 0;
  int out_idx = 0, out_src = 0;
  logic [15:0] out_len;
  string scen = "R6";
  logic [15:0] exp_rx[$], exp_fwd[$], exp_inj[$];
  int src_log[$];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(negedge clk) begin
    rx_ready       = (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    ring_out_ready = (out_mode == 0) ? 1'b1 : (out_mode == 1) ? (cyc % 4 < 2) : 1'b0;
  end

  // Reference model: every clock, each handshake is compared with the expected word streams.
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      out_idx = 0;
    end else begin
      if (ring_in_valid && ring_in_ready) acc_cnt++;
      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) check(1'b0, scen, "unexpected delivered word", rx_data, 0);
        else begin
          logic [15:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R6", "delivered word", rx_data, e);
        end
      end
      if (ring_out_valid && ring_out_ready) begin
        if (out_idx == 0) begin
          if (exp_inj.size() != 0 && ring_out_data == exp_inj[0] &&
              (exp_fwd.size() == 0 || ring_out_data != exp_fwd[0])) out_src = 2;
          else out_src = 1;
          src_log.push_back(out_src);
        end
        if (out_src == 2) begin
          if (exp_inj.size() == 0) check(1'b0, "R9", "unexpected injected word", ring_out_data, 0);
          else begin
            logic [15:0] e;
            e = exp_inj.pop_front();
            check(ring_out_data == e, "R9", "injected word on ring", ring_out_data, e);
          end
        end else begin
          if (exp_fwd.size() == 0) check(1'b0, scen, "unexpected forwarded word", ring_out_data, 0);
          else begin
            logic [15:0] e;
            e = exp_fwd.pop_front();
            check(ring_out_data == e, "R6", "forwarded word", ring_out_data, e);
          end
        end
        if (out_idx == 1) out_len = ring_out_data;
        if (out_idx >= 2 && (out_idx - 2) == int'(out_len)) out_idx = 0;
        else out_idx++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_ring(input logic [1:0] cls, input logic [13:0] id, input logic [13:0] origin,
                           input int len, input logic [15:0] base);
    logic [15:0] w[$];
    bit dlv, fwd;
    w.push_back({cls, id});
    w.push_back(16'(len));
    w.push_back({2'b00, origin});
    for (int i = 0; i < len; i++) w.push_back(base + 16'(i));
    case (cls)
      2'b00: begin dlv = (id == NID); fwd = (id != NID); end
      2'b01: begin dlv = (origin != NID) && (id == GID); fwd = (origin != NID); end
      2'b10: begin dlv = (origin != NID); fwd = (origin != NID); end
      default: begin dlv = 0; fwd = 1; end
    endcase
    foreach (w[i]) begin
      if (dlv) exp_rx.push_back(w[i]);
      if (fwd) exp_fwd.push_back(w[i]);
    end
    foreach (w[i]) begin
      @(negedge clk);
      ring_in_valid = 1'b1;
      ring_in_data  = w[i];
      #1;
      while (!ring_in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    ring_in_valid = 1'b0;
  endtask

  task automatic send_inj(input logic [13:0] id, input int len, input logic [15:0] base);
    logic [15:0] w[$];
    w.push_back({2'b11, id});
    w.push_back(16'(len));
    w.push_back({2'b00, NID});
    for (int i = 0; i < len; i++) w.push_back(base + 16'(i));
    foreach (w[i]) exp_inj.push_back(w[i]);
    foreach (w[i]) begin
      @(negedge clk);
      inj_valid = 1'b1;
      inj_data  = w[i];
      #1;
      while (!inj_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic drain_and_check(input string tag);
    repeat (80) @(negedge clk);
    check(exp_rx.size() == 0, tag, "delivered words missing", exp_rx.size(), 0);
    check(exp_fwd.size() == 0, tag, "forwarded words missing", exp_fwd.size(), 0);
    check(exp_inj.size() == 0, tag, "injected words missing", exp_inj.size(), 0);
  endtask

  initial begin
    int base_cnt;
    rst_n = 1'b0; ring_in_valid = 1'b0; ring_in_data = '0;
    inj_valid = 1'b0; inj_data = '0;
    cfg_rx_limit = '0; cfg_fwd_limit = '0;
    rx_ready = 1'b1; ring_out_ready = 1'b1;
    do_reset();

    #2;
    check(rx_valid == 1'b0, "R11", "rx_valid after reset", rx_valid, 0);
    check(ring_out_valid == 1'b0, "R11", "ring_out_valid after reset", ring_out_valid, 0);
    check(ring_in_ready == 1'b1, "R11", "ring_in_ready after reset", ring_in_ready, 1);

    scen = "R2";
    send_ring(2'b00, NID, 14'h0007, 2, 16'hA000);
    send_ring(2'b00, 14'h0200, 14'h0007, 1, 16'hA100);
    drain_and_check("R2");

    scen = "R3";
    send_ring(2'b01, GID, 14'h0007, 2, 16'hB000);
    send_ring(2'b01, 14'h0046, 14'h0007, 1, 16'hB100);
    send_ring(2'b01, GID, NID, 2, 16'hB200);
    drain_and_check("R3");

    scen = "R4";
    send_ring(2'b10, 14'h0000, 14'h0009, 3, 16'hC000);
    send_ring(2'b10, 14'h0000, NID, 2, 16'hC100);
    drain_and_check("R4");

    scen = "R5";
    send_ring(2'b11, NID, 14'h0009, 2, 16'hD000);
    drain_and_check("R5");

    scen = "R1";
    send_ring(2'b00, NID, 14'h0002, 0, 16'h0000);
    send_ring(2'b10, 14'h0001, 14'h0002, 0, 16'h0000);
    drain_and_check("R1");

    scen = "R7";
    rx_mode = 1; out_mode = 1;
    send_ring(2'b10, 14'h0000, 14'h0011, 4, 16'hE000);
    send_ring(2'b00, NID, 14'h0011, 5, 16'hE100);
    send_ring(2'b01, GID, 14'h0011, 4, 16'hE200);
    send_ring(2'b11, 14'h0300, 14'h0011, 6, 16'hE300);
    drain_and_check("R7");
    rx_mode = 0; out_mode = 0;

    scen = "R8";
    cfg_rx_limit = 5'd2; rx_mode = 2;
    base_cnt = acc_cnt;
    fork
      send_ring(2'b00, NID, 14'h0005, 4, 16'hF000);
      begin
        repeat (30) @(negedge clk);
        check(acc_cnt - base_cnt == 3, "R8", "words accepted with limit 2", acc_cnt - base_cnt, 3);
        cfg_rx_limit = 5'd5;
        repeat (30) @(negedge clk);
        check(acc_cnt - base_cnt == 5, "R8", "words accepted with limit 5", acc_cnt - base_cnt, 5);
        rx_mode = 0;
      end
    join
    drain_and_check("R8");
    cfg_rx_limit = '0;

    scen = "R10";
    do_reset();
    src_log.delete();
    out_mode = 2;
    fork
      begin
        send_ring(2'b00, 14'h0200, 14'h0003, 2, 16'h5000);
        send_ring(2'b00, 14'h0201, 14'h0003, 2, 16'h5100);
        repeat (15) @(negedge clk);
        out_mode = 0;
      end
      begin
        send_inj(14'h3001, 2, 16'h6000);
        send_inj(14'h3002, 2, 16'h6100);
      end
    join
    drain_and_check("R9");
    check(src_log.size() == 4, "R10", "packet count on ring", src_log.size(), 4);
    if (src_log.size() == 4) begin
      check(src_log[0] == 1, "R10", "first packet source", src_log[0], 1);
      check(src_log[1] == 2, "R10", "second packet source", src_log[1], 2);
      check(src_log[2] == 1, "R10", "third packet source", src_log[2], 1);
      check(src_log[3] == 2, "R10", "fourth packet source", src_log[3], 2);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule